// File: doc/BRIEF.md
# CAN Node Fault Confinement Unit

This block keeps the two fault counters of one CAN node, the transmit error count and the receive error count. From them it derives the node's fault state: error-active, error-passive or bus-off. The protocol engine feeds it one-cycle event pulses:

- receiver errors
- error flags sent while transmitting, with a qualifier for the cases that are exempt from the penalty
- bit errors seen while driving an active error flag or an overload flag
- the end of the node's own error flag
- per-bit samples of the bus level after that flag
- successful transmit and successful receive
- each detection of eleven consecutive recessive bits

An internal tracker counts dominant bits after the node's own error flag. It raises the penalties for the first dominant bit and for over-long dominant runs. The threshold depends on whether the flag was active or passive.

The outputs are the two counters, the fault state and a flag-type select that tells the engine to send passive flags instead of active ones. There is also a transmit inhibit that holds the node off the bus while bus-off, and a warning for heavy disturbance. A bus-off node is held frozen until 128 eleven-recessive-bit detections have been reported. It then rejoins the bus as error-active with both counters cleared. All outputs are registered and change on the clock edge that samples the event.

Top module: `can_fault_confine`

## Requirements
- R1: After reset, tec=0, rec=0, fault_state=2'b00 (error-active), and flag_passive, tx_inhibit and warn are 0.
- R2: A pulse on ev_rx_err adds 1 to rec. A pulse on ev_flag_bit_err while node_is_tx=0 changes neither counter.
- R3: A pulse on ev_tx_flag adds 8 to tec unless ev_tx_exempt is high in the same cycle, in which case tec is unchanged. A pulse on ev_flag_bit_err while node_is_tx=1 adds 8 to tec. Penalties that arrive in the same cycle add up.
- R4: After ev_flag_end, the first bit_tick with bit_dom=1 adds 8 to rec when node_is_tx=0. It adds nothing to tec when node_is_tx=1.
- R5: Dominant bits after ev_flag_end are counted. The sequence is counted as active if flag_passive=0 when ev_flag_end arrives, and as passive otherwise:
  - After an active flag, the 14th dominant bit adds 8, and so does every further 8th (22nd, 30th, ...).
  - After a passive flag, the 8th, 16th, ... dominant bits each add 8.
  - The penalty goes to tec when node_is_tx=1 and to rec otherwise.
  - A bit_tick with bit_dom=0 ends the sequence.
- R6: ev_tx_ok lowers tec by 1 when tec is non-zero, and leaves 0 at 0. It is ignored in a cycle that raises tec.
- R7: ev_rx_ok lowers rec by 1 when rec is 1..127, keeps 0 at 0, and loads 127 when rec is 128 or more. It is ignored in a cycle that raises rec.
- R8: When tec>=128 or rec>=128 (and not bus-off), fault_state=2'b01 and flag_passive=1. When both fall to 127 or below, the node returns to 2'b00.
- R9: When tec reaches 256 or more, fault_state=2'b10 and tx_inhibit=1. While bus-off, every counting event is ignored and both counters hold.
- R10: In bus-off, the 128th ev_idle11 pulse clears tec and rec and returns fault_state to 2'b00. ev_idle11 pulses outside bus-off do not count toward recovery.
- R11: warn is 1 exactly when tec>96 or rec>96.
- R12: rec saturates at 255 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_is_tx | input | 1 | Node is the current transmitter |
| ev_rx_err | input | 1 | Receiver detected an error |
| ev_tx_flag | input | 1 | Transmitter sent an error flag |
| ev_tx_exempt | input | 1 | Qualifies ev_tx_flag as an exempt case |
| ev_flag_bit_err | input | 1 | Bit error while driving an active error or overload flag |
| ev_flag_end | input | 1 | Node's own error flag has just ended |
| bit_tick | input | 1 | One bus bit sampled this cycle |
| bit_dom | input | 1 | Level of the sampled bit, 1 = dominant |
| ev_tx_ok | input | 1 | Frame transmitted successfully |
| ev_rx_ok | input | 1 | Frame received successfully |
| ev_idle11 | input | 1 | Eleven consecutive recessive bits detected |
| tec | output | 9 | Transmit error count |
| rec | output | 8 | Receive error count |
| fault_state | output | 2 | 00 active, 01 passive, 10 bus-off |
| flag_passive | output | 1 | Send passive error flags |
| tx_inhibit | output | 1 | Node must not drive the bus |
| warn | output | 1 | Heavy disturbance warning |

## Verification
The bench targets these corner cases:

- A decrement in the same cycle as a penalty: a design that applied both would leave tec 1 low.
- A good receive with rec above 127: a naive decrement would keep the node error-passive when it should return to error-active.
- The 13th versus 14th, and 7th versus 8th, dominant bits of the two flag kinds, plus the repeat every 8 bits: an off-by-one tracker shifts every penalty.
- rec reaching 255, which would wrap to 0 without saturation.
- The recovery counter: a design that counted eleven-recessive detections outside bus-off would leave bus-off after a single detection.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'b00,
    FC_PASSIVE = 2'b01,
    FC_BUSOFF  = 2'b10
  } fc_state_t;
endpackage

// File: rtl/can_fc_domseq.sv
// Counts dominant bits after the node's own error flag and flags the
// first one and each over-long run.
module can_fc_domseq #(
  parameter int ACT_LIM = 14,
  parameter int PAS_LIM = 8,
  parameter int RPT     = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic flag_end,
  input  logic flag_passive,
  input  logic bit_tick,
  input  logic bit_dom,
  output logic first_dom,
  output logic long_dom
);
  localparam int LIM_MAX = (ACT_LIM > PAS_LIM) ? ACT_LIM : PAS_LIM;
  localparam int CW      = $clog2(LIM_MAX + 1);

  logic          armed;
  logic          seen;
  logic [CW-1:0] cnt;
  logic [CW-1:0] thr;
  logic [CW-1:0] cnt_inc;
  logic          dom_bit;

  assign cnt_inc   = cnt + CW'(1);
  assign dom_bit   = armed && bit_tick && bit_dom && !flag_end;
  assign first_dom = dom_bit && !seen;
  assign long_dom  = dom_bit && (cnt_inc == thr);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      seen  <= 1'b0;
      cnt   <= '0;
      thr   <= CW'(ACT_LIM);
    end else if (flag_end) begin
      armed <= 1'b1;
      seen  <= 1'b0;
      cnt   <= '0;
      thr   <= flag_passive ? CW'(PAS_LIM) : CW'(ACT_LIM);
    end else if (armed && bit_tick) begin
      if (bit_dom) begin
        seen <= 1'b1;
        cnt  <= long_dom ? (thr - CW'(RPT)) : cnt_inc;
      end else begin
        armed <= 1'b0;
      end
    end
  end

  AST_DOM_NO_EARLY: assert property (@(posedge clk) disable iff (rst)
    flag_end |=> !long_dom); // R5
endmodule

// File: rtl/can_fc_tec.sv
// Transmit error counter: stepped penalties, single decrement, saturation.
module can_fc_tec #(
  parameter int TEC_W = 9,
  parameter int STEP  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             clr,
  input  logic [1:0]       n_inc,
  input  logic             dec,
  output logic [TEC_W-1:0] tec_d,
  output logic [TEC_W-1:0] tec_q
);
  localparam logic [TEC_W:0] CAP = {1'b0, {TEC_W{1'b1}}};

  logic [TEC_W-1:0] add_amt;
  logic [TEC_W:0]   wide;

  assign add_amt = TEC_W'(n_inc) * TEC_W'(STEP);
  assign wide    = {1'b0, tec_q} + {1'b0, add_amt};

  always_comb begin
    if (clr)                      tec_d = '0;
    else if (hold)                tec_d = tec_q;
    else if (n_inc != 2'd0)       tec_d = (wide > CAP) ? CAP[TEC_W-1:0] : wide[TEC_W-1:0];
    else if (dec && tec_q != '0)  tec_d = tec_q - TEC_W'(1);
    else                          tec_d = tec_q;
  end

  always_ff @(posedge clk) begin
    if (rst) tec_q <= '0;
    else     tec_q <= tec_d;
  end

  AST_TEC_DEC_ONE: assert property (@(posedge clk) disable iff (rst)
    (!clr && !hold && n_inc == 2'd0 && dec && tec_q != '0)
      |=> tec_q == $past(tec_q) - TEC_W'(1)); // R6
  AST_TEC_STEP: assert property (@(posedge clk) disable iff (rst)
    (!clr && !hold && n_inc == 2'd1 && tec_q < TEC_W'(2**(TEC_W-1)))
      |=> tec_q == $past(tec_q) + TEC_W'(STEP)); // R3
endmodule

// File: rtl/can_fc_rec.sv
// Receive error counter: +1 / +STEP penalties, saturation, reload rule.
module can_fc_rec #(
  parameter int REC_W    = 8,
  parameter int STEP     = 8,
  parameter int PASS_LIM = 128,
  parameter int RELOAD   = 127
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             clr,
  input  logic             inc_one,
  input  logic [1:0]       n_big,
  input  logic             ok,
  output logic [REC_W-1:0] rec_d,
  output logic [REC_W-1:0] rec_q
);
  localparam logic [REC_W:0]   CAP    = {1'b0, {REC_W{1'b1}}};
  localparam logic [REC_W-1:0] LIM    = REC_W'(PASS_LIM);
  localparam logic [REC_W-1:0] RELV   = REC_W'(RELOAD);

  logic [REC_W:0] wide;
  logic           any_inc;

  assign any_inc = inc_one || (n_big != 2'd0);
  assign wide    = {1'b0, rec_q} + (REC_W+1)'(inc_one)
                 + (REC_W+1)'(n_big) * (REC_W+1)'(STEP);

  always_comb begin
    if (clr)               rec_d = '0;
    else if (hold)         rec_d = rec_q;
    else if (any_inc)      rec_d = (wide > CAP) ? CAP[REC_W-1:0] : wide[REC_W-1:0];
    else if (ok) begin
      if (rec_q >= LIM)        rec_d = RELV;
      else if (rec_q != '0)    rec_d = rec_q - REC_W'(1);
      else                     rec_d = rec_q;
    end
    else                   rec_d = rec_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rec_q <= '0;
    else     rec_q <= rec_d;
  end

  AST_REC_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!clr && !hold && !ok) |=> rec_q >= $past(rec_q)); // R12
  AST_REC_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (!clr && !hold && ok && !any_inc && rec_q >= LIM) |=> rec_q == RELV); // R7
endmodule

// File: rtl/can_fc_recover.sv
// Counts eleven-recessive detections while bus-off.
module can_fc_recover #(
  parameter int N = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic busoff,
  input  logic idle11,
  output logic done
);
  localparam int CW = $clog2(N);

  logic [CW-1:0] cnt;

  assign done = busoff && idle11 && (cnt == CW'(N - 1));

  always_ff @(posedge clk) begin
    if (rst || !busoff) cnt <= '0;
    else if (idle11)    cnt <= done ? '0 : cnt + CW'(1);
  end

  AST_RECOVER_RESTART: assert property (@(posedge clk) disable iff (rst)
    !busoff |=> !done); // R10
endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine
  import can_fc_pkg::*;
#(
  parameter int TEC_W       = 9,
  parameter int REC_W       = 8,
  parameter int STEP        = 8,
  parameter int PASS_LIM    = 128,
  parameter int BUSOFF_LIM  = 256,
  parameter int WARN_LIM    = 96,
  parameter int REC_RELOAD  = 127,
  parameter int RECOVER_N   = 128,
  parameter int ACT_DOM_LIM = 14,
  parameter int PAS_DOM_LIM = 8,
  parameter int DOM_RPT     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             node_is_tx,
  input  logic             ev_rx_err,
  input  logic             ev_tx_flag,
  input  logic             ev_tx_exempt,
  input  logic             ev_flag_bit_err,
  input  logic             ev_flag_end,
  input  logic             bit_tick,
  input  logic             bit_dom,
  input  logic             ev_tx_ok,
  input  logic             ev_rx_ok,
  input  logic             ev_idle11,
  output logic [TEC_W-1:0] tec,
  output logic [REC_W-1:0] rec,
  output logic [1:0]       fault_state,
  output logic             flag_passive,
  output logic             tx_inhibit,
  output logic             warn
);
  localparam logic [TEC_W-1:0] TEC_OFF  = TEC_W'(BUSOFF_LIM);
  localparam logic [TEC_W-1:0] TEC_PASS = TEC_W'(PASS_LIM);
  localparam logic [REC_W-1:0] REC_PASS = REC_W'(PASS_LIM);
  localparam logic [TEC_W-1:0] TEC_WARN = TEC_W'(WARN_LIM);
  localparam logic [REC_W-1:0] REC_WARN = REC_W'(WARN_LIM);

  fc_state_t        st_q, st_d;
  logic             busoff;
  logic             rcv_done;
  logic             first_dom, long_dom;
  logic [1:0]       tec_n, rec_n;
  logic [TEC_W-1:0] tec_d;
  logic [REC_W-1:0] rec_d;

  assign busoff = (st_q == FC_BUSOFF);

  can_fc_domseq #(
    .ACT_LIM(ACT_DOM_LIM), .PAS_LIM(PAS_DOM_LIM), .RPT(DOM_RPT)
  ) u_domseq (
    .clk(clk), .rst(rst),
    .flag_end(ev_flag_end), .flag_passive(flag_passive),
    .bit_tick(bit_tick), .bit_dom(bit_dom),
    .first_dom(first_dom), .long_dom(long_dom)
  );

  // penalty counts of STEP for each counter
  assign tec_n = 2'(ev_tx_flag && !ev_tx_exempt)
               + 2'(ev_flag_bit_err && node_is_tx)
               + 2'(long_dom && node_is_tx);
  assign rec_n = 2'(first_dom && !node_is_tx)
               + 2'(long_dom && !node_is_tx);

  can_fc_tec #(.TEC_W(TEC_W), .STEP(STEP)) u_tec (
    .clk(clk), .rst(rst), .hold(busoff), .clr(rcv_done),
    .n_inc(tec_n), .dec(ev_tx_ok), .tec_d(tec_d), .tec_q(tec)
  );

  can_fc_rec #(
    .REC_W(REC_W), .STEP(STEP), .PASS_LIM(PASS_LIM), .RELOAD(REC_RELOAD)
  ) u_rec (
    .clk(clk), .rst(rst), .hold(busoff), .clr(rcv_done),
    .inc_one(ev_rx_err), .n_big(rec_n), .ok(ev_rx_ok),
    .rec_d(rec_d), .rec_q(rec)
  );

  can_fc_recover #(.N(RECOVER_N)) u_recover (
    .clk(clk), .rst(rst), .busoff(busoff), .idle11(ev_idle11), .done(rcv_done)
  );

  always_comb begin
    if (rcv_done)                                st_d = FC_ACTIVE;
    else if (busoff || tec_d >= TEC_OFF)         st_d = FC_BUSOFF;
    else if (tec_d >= TEC_PASS || rec_d >= REC_PASS) st_d = FC_PASSIVE;
    else                                         st_d = FC_ACTIVE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= FC_ACTIVE;
      flag_passive <= 1'b0;
      tx_inhibit   <= 1'b0;
      warn         <= 1'b0;
    end else begin
      st_q         <= st_d;
      flag_passive <= (st_d == FC_PASSIVE);
      tx_inhibit   <= (st_d == FC_BUSOFF);
      warn         <= (tec_d > TEC_WARN) || (rec_d > REC_WARN);
    end
  end

  assign fault_state = st_q;

  AST_BUSOFF_INHIBIT: assert property (@(posedge clk) disable iff (rst)
    (fault_state == FC_BUSOFF) |-> tx_inhibit); // R9
  AST_BUSOFF_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (fault_state == FC_BUSOFF && !rcv_done) |=> $stable(tec) && $stable(rec)); // R9
  AST_PASSIVE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (fault_state == FC_PASSIVE) |-> (tec >= TEC_PASS || rec >= REC_PASS)); // R8
  AST_WARN_QUIET: assert property (@(posedge clk) disable iff (rst)
    (tec <= TEC_WARN && rec <= REC_WARN) |-> !warn); // R11
endmodule

// File: tb/tb_can_fault_confine.sv
module tb_can_fault_confine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic node_is_tx = 1'b0;
  logic ev_rx_err = 0, ev_tx_flag = 0, ev_tx_exempt = 0, ev_flag_bit_err = 0;
  logic ev_flag_end = 0, bit_tick = 0, bit_dom = 0;
  logic ev_tx_ok = 0, ev_rx_ok = 0, ev_idle11 = 0;
  logic [8:0] tec;
  logic [7:0] rec;
  logic [1:0] fault_state;
  logic flag_passive, tx_inhibit, warn;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  can_fault_confine dut (
    .clk(clk), .rst(rst), .node_is_tx(node_is_tx),
    .ev_rx_err(ev_rx_err), .ev_tx_flag(ev_tx_flag), .ev_tx_exempt(ev_tx_exempt),
    .ev_flag_bit_err(ev_flag_bit_err), .ev_flag_end(ev_flag_end),
    .bit_tick(bit_tick), .bit_dom(bit_dom),
    .ev_tx_ok(ev_tx_ok), .ev_rx_ok(ev_rx_ok), .ev_idle11(ev_idle11),
    .tec(tec), .rec(rec), .fault_state(fault_state),
    .flag_passive(flag_passive), .tx_inhibit(tx_inhibit), .warn(warn)
  );

  // event code bits
  localparam logic [9:0] E_RXERR = 10'd1;
  localparam logic [9:0] E_TXFLG = 10'd2;
  localparam logic [9:0] E_EXMPT = 10'd4;
  localparam logic [9:0] E_FBE   = 10'd8;
  localparam logic [9:0] E_FEND  = 10'd16;
  localparam logic [9:0] E_DOM   = 10'd32;
  localparam logic [9:0] E_RECS  = 10'd64;
  localparam logic [9:0] E_TXOK  = 10'd128;
  localparam logic [9:0] E_RXOK  = 10'd256;
  localparam logic [9:0] E_IDLE  = 10'd512;

  // {node_is_tx, events, expected tec, expected rec, requirement number}
  localparam int NV = 13;
  localparam logic [31:0] VEC [NV] = '{
    {1'b0, E_RXERR,          9'd0,  8'd1, 4'd2},  // R2
    {1'b0, E_RXERR,          9'd0,  8'd2, 4'd2},  // R2
    {1'b0, E_FBE,            9'd0,  8'd2, 4'd2},  // R2 receiver flag bit error ignored
    {1'b1, E_TXFLG,          9'd8,  8'd2, 4'd3},  // R3
    {1'b1, E_TXFLG|E_EXMPT,  9'd8,  8'd2, 4'd3},  // R3 exempt
    {1'b1, E_FBE,            9'd16, 8'd2, 4'd3},  // R3
    {1'b1, E_TXFLG|E_FBE,    9'd32, 8'd2, 4'd3},  // R3 penalties add
    {1'b1, E_TXOK,           9'd31, 8'd2, 4'd6},  // R6
    {1'b1, E_TXFLG|E_TXOK,   9'd39, 8'd2, 4'd6},  // R6 decrement dropped
    {1'b0, E_RXOK,           9'd39, 8'd1, 4'd7},  // R7
    {1'b0, E_RXOK,           9'd39, 8'd0, 4'd7},  // R7
    {1'b0, E_RXOK,           9'd39, 8'd0, 4'd7},  // R7 stays at zero
    {1'b0, E_RXERR|E_RXOK,   9'd39, 8'd1, 4'd7}   // R7 decrement dropped
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic fire(input logic [9:0] e);
    @(negedge clk);
    ev_rx_err       = e[0];
    ev_tx_flag      = e[1];
    ev_tx_exempt    = e[2];
    ev_flag_bit_err = e[3];
    ev_flag_end     = e[4];
    bit_tick        = e[5] | e[6];
    bit_dom         = e[5];
    ev_tx_ok        = e[7];
    ev_rx_ok        = e[8];
    ev_idle11       = e[9];
    @(negedge clk);
    {ev_rx_err, ev_tx_flag, ev_tx_exempt, ev_flag_bit_err, ev_flag_end} = '0;
    {bit_tick, bit_dom, ev_tx_ok, ev_rx_ok, ev_idle11} = '0;
  endtask

  task automatic fire_n(input logic [9:0] e, input int n);
    for (int k = 0; k < n; k++) fire(e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 tec", int'(tec), 0);
    chk("R1 rec", int'(rec), 0);
    chk("R1 state", int'(fault_state), 0);
    chk("R1 flags", int'({flag_passive, tx_inhibit, warn}), 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      node_is_tx = VEC[i][31];
      fire(VEC[i][30:21]);
      chk($sformatf("R%0d vec%0d tec", VEC[i][3:0], i), int'(tec), int'(VEC[i][20:12]));
      chk($sformatf("R%0d vec%0d rec", VEC[i][3:0], i), int'(rec), int'(VEC[i][11:4]));
      chk($sformatf("R%0d vec%0d state", VEC[i][3:0], i), int'(fault_state), 0);
    end

    // R11 warning, R8 passive entry and exit
    do_reset();
    node_is_tx = 1'b1;
    fire_n(E_TXFLG, 12);
    chk("R11 tec96", int'(tec), 96);
    chk("R11 warn off at 96", int'(warn), 0);
    fire(E_TXFLG);
    chk("R11 warn on at 104", int'(warn), 1);
    fire_n(E_TXFLG, 2);
    chk("R8 active at 120", int'(fault_state), 0);
    fire(E_TXFLG);
    chk("R8 passive at 128", int'(fault_state), 1);
    chk("R8 flag_passive", int'(flag_passive), 1);
    fire(E_TXOK);
    chk("R8 back active at 127", int'(fault_state), 0);
    chk("R8 flag_passive cleared", int'(flag_passive), 0);

    // R9 bus-off and freeze
    fire_n(E_TXFLG, 16);
    chk("R9 tec255", int'(tec), 255);
    chk("R9 passive at 255", int'(fault_state), 1);
    fire(E_TXFLG);
    chk("R9 busoff", int'(fault_state), 2);
    chk("R9 inhibit", int'(tx_inhibit), 1);
    fire(E_TXFLG | E_RXERR);
    fire(E_TXOK | E_RXOK);
    chk("R9 tec held", int'(tec), 263);
    chk("R9 rec held", int'(rec), 0);

    // R10 recovery
    fire_n(E_IDLE, 127);
    chk("R10 still busoff after 127", int'(fault_state), 2);
    fire(E_IDLE);
    chk("R10 active after 128", int'(fault_state), 0);
    chk("R10 tec cleared", int'(tec), 0);
    chk("R10 inhibit off", int'(tx_inhibit), 0);
    fire_n(E_IDLE, 127);
    fire_n(E_TXFLG, 32);
    chk("R10 busoff again", int'(fault_state), 2);
    fire(E_IDLE);
    chk("R10 idle pulses before busoff not counted", int'(fault_state), 2);
    chk("R10 tec held 256", int'(tec), 256);

    // R7 reload and R12 saturation
    do_reset();
    node_is_tx = 1'b0;
    fire_n(E_RXERR, 130);
    chk("R8 rec passive", int'(fault_state), 1);
    fire(E_RXOK);
    chk("R7 reload 127", int'(rec), 127);
    chk("R7 reload active", int'(fault_state), 0);
    fire_n(E_RXERR, 130);
    chk("R12 saturate", int'(rec), 255);

    // R4 / R5 dominant tracking
    do_reset();
    node_is_tx = 1'b0;
    fire(E_FEND);
    fire(E_DOM);
    chk("R4 first dominant rx", int'(rec), 8);
    fire_n(E_DOM, 12);
    chk("R5 13th active no penalty", int'(rec), 8);
    fire(E_DOM);
    chk("R5 14th active penalty", int'(rec), 16);
    fire_n(E_DOM, 7);
    chk("R5 21st no penalty", int'(rec), 16);
    fire(E_DOM);
    chk("R5 22nd penalty", int'(rec), 24);
    fire(E_RECS);
    fire_n(E_DOM, 20);
    chk("R5 recessive ends sequence", int'(rec), 24);
    node_is_tx = 1'b1;
    fire(E_FEND);
    fire_n(E_DOM, 13);
    chk("R4 first dominant tx no penalty", int'(tec), 0);
    fire(E_DOM);
    chk("R5 14th tx penalty", int'(tec), 8);
    fire(E_RECS);
    fire_n(E_RXERR, 104);
    chk("R8 passive via rec", int'(flag_passive), 1);
    fire(E_FEND);
    fire_n(E_DOM, 7);
    chk("R5 passive 7th no penalty", int'(tec), 8);
    fire(E_DOM);
    chk("R5 passive 8th penalty", int'(tec), 16);
    fire_n(E_DOM, 8);
    chk("R5 passive 16th penalty", int'(tec), 24);

    summary();
  end
endmodule